// File: doc/BRIEF.md
# Thread Block Admission Controller

The controller sits in front of one streaming multiprocessor. It decides whether a newly launched thread block may become resident there, and it keeps the occupancy counts that drive that decision. A launch request carries the block's thread count. The controller weighs that count against two budgets at the same time: the number of resident blocks and the number of resident threads. A block is always taken whole and is never split. Whichever budget would be exceeded stalls the request. The request stays pending under a valid/ready handshake until a completion frees enough room.

On acceptance the block gets the lowest-numbered free slot. The controller reports that slot and the number of warps the block needs: the thread count divided by the warp width and rounded up. Each slot remembers its block's thread count. A completion naming the slot therefore returns exactly that many threads to the budget. A completion and a launch in the same cycle are both applied. The release is counted before the launch is judged.

Top module: `sm_admit_ctrl`

## Requirements
- R1: After reset, used_blocks and used_threads are 0 and resp_valid, resp_ok, resp_slot and resp_warps are 0. A request of 1 to 1024 threads then sees req_ready high.
- R2: A request with a thread count of 0 or above 1024 is consumed at once (req_ready high). One cycle later it is answered with resp_valid=1, resp_ok=0, resp_slot=0 and resp_warps=0, and it leaves both occupancy counts unchanged.
- R3: No more than 8 blocks are resident at once. With 64-thread blocks the ninth request sees req_ready low while used_threads reads 512.
- R4: No more than 1536 threads are resident at once. With 256-thread blocks the seventh request sees req_ready low while 6 blocks are resident.
- R5: An accepted block reports resp_warps equal to its thread count divided by 32 and rounded up: 1 thread gives 1, 33 gives 2, 256 gives 8 and 1024 gives 32.
- R6: An accepted block is placed in the lowest-numbered free slot, reported on resp_slot. The slots are numbered 0 to 7.
- R7: A completion (done_valid with done_slot naming an occupied slot) frees that slot. One cycle later it lowers used_blocks by 1 and used_threads by exactly that block's thread count.
- R8: A completion naming an unoccupied slot has no effect on used_blocks, used_threads or slot allocation.
- R9: When a completion and a request arrive in the same cycle, the freed slot and threads count toward that request's admission. The freed slot may be handed to that request.
- R10: A request that does not fit sees req_ready low and is not consumed. Once capacity is freed, req_ready rises in that same cycle and the request is accepted.
- R11: Every handshake (req_valid and req_ready both high) is answered by a one-cycle resp_valid pulse on the next cycle. In cycles with no handshake, resp_valid, resp_ok, resp_slot and resp_warps are 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Launch request present |
| req_threads | input | 11 | Thread count of the requested block |
| req_ready | output | 1 | Request consumed this cycle (fits, or is malformed) |
| resp_valid | output | 1 | Response for the previous cycle's handshake |
| resp_ok | output | 1 | Block was admitted |
| resp_slot | output | 3 | Slot given to the admitted block |
| resp_warps | output | 6 | Warps needed by the admitted block |
| done_valid | input | 1 | A resident block has completed |
| done_slot | input | 3 | Slot of the completed block |
| used_blocks | output | 4 | Resident block count |
| used_threads | output | 11 | Resident thread count |

## Verification
req_ready is combinational. It is due in the same cycle as the request and the completion that affect it, so the bench compares it a short time after driving inputs on the falling edge. resp_valid, resp_ok, resp_slot, resp_warps, used_blocks and used_threads pass through one register and are due on the next rising edge. They are compared on the following falling edge against a behavioural model that is advanced once per cycle. Stalls are held across several cycles, and completions land in the same cycle as a pending request, so both the pending and the release-first orderings are checked at those exact edges.

// File: rtl/admit_pkg.sv
package admit_pkg;
   localparam int DEF_MAX_BLOCKS    = 8;
   localparam int DEF_MAX_THREADS   = 1536;
   localparam int DEF_BLOCK_THREADS = 1024;
   localparam int DEF_WARP_SIZE     = 32;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/admit_lowfree.sv
module admit_lowfree #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  busy,
   output logic [IW-1:0] idx,
   output logic          any_free
);
   always_comb begin
      idx      = '0;
      any_free = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            idx      = IW'(i);
            any_free = 1'b1;
         end
      end
   end
endmodule

// File: rtl/admit_warps.sv
module admit_warps #(
   parameter int TW = 11,
   parameter int WW = 6,
   parameter int WS = 32
) (
   input  logic [TW-1:0] threads,
   output logic [WW-1:0] warps
);
   localparam int SH = $clog2(WS);
   logic [TW:0] padded;

   assign padded = {1'b0, threads} + (TW+1)'(WS - 1);

   generate
      if (admit_pkg::is_pow2(WS)) begin : g_shift
         assign warps = WW'(padded >> SH);
      end else begin : g_div
         assign warps = WW'(padded / (TW+1)'(WS));
      end
   endgenerate
endmodule

// File: rtl/admit_slot_table.sv
module admit_slot_table #(
   parameter int N  = 8,
   parameter int SW = 3,
   parameter int TW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_en,
   input  logic [SW-1:0] alloc_slot,
   input  logic [TW-1:0] alloc_thr,
   input  logic          rel_req,
   input  logic [SW-1:0] rel_slot,
   output logic [N-1:0]  occ,
   output logic          rel_hit,
   output logic [TW-1:0] rel_thr
);
   logic [TW-1:0] thr_q [N];
   logic          rel_in_range;

   assign rel_in_range = (int'(rel_slot) < N);

   generate
      for (genvar s = 0; s < N; s++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               occ[s]   <= 1'b0;
               thr_q[s] <= '0;
            end else if (alloc_en && int'(alloc_slot) == s) begin
               occ[s]   <= 1'b1;
               thr_q[s] <= alloc_thr;
            end else if (rel_hit && int'(rel_slot) == s) begin
               occ[s]   <= 1'b0;
            end
         end
      end
   endgenerate

   always_comb begin
      rel_hit = 1'b0;
      rel_thr = '0;
      if (rel_req && rel_in_range) begin
         for (int s = 0; s < N; s++) begin
            if (int'(rel_slot) == s) begin
               rel_hit = occ[s];
               rel_thr = occ[s] ? thr_q[s] : '0;
            end
         end
      end
   end
endmodule

// File: rtl/sm_admit_ctrl.sv
module sm_admit_ctrl #(
   parameter int MAX_BLOCKS    = admit_pkg::DEF_MAX_BLOCKS,
   parameter int MAX_THREADS   = admit_pkg::DEF_MAX_THREADS,
   parameter int BLOCK_THREADS = admit_pkg::DEF_BLOCK_THREADS,
   parameter int WARP_SIZE     = admit_pkg::DEF_WARP_SIZE,
   parameter int TW = $clog2(BLOCK_THREADS + 1),
   parameter int SW = $clog2(MAX_BLOCKS),
   parameter int WW = $clog2((BLOCK_THREADS + WARP_SIZE - 1) / WARP_SIZE + 1),
   parameter int BW = $clog2(MAX_BLOCKS + 1),
   parameter int UW = $clog2(MAX_THREADS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [TW-1:0] req_threads,
   output logic          req_ready,
   output logic          resp_valid,
   output logic          resp_ok,
   output logic [SW-1:0] resp_slot,
   output logic [WW-1:0] resp_warps,
   input  logic          done_valid,
   input  logic [SW-1:0] done_slot,
   output logic [BW-1:0] used_blocks,
   output logic [UW-1:0] used_threads
);
   generate
      if (MAX_BLOCKS < 2)                 begin : g_e0 $error("MAX_BLOCKS must be at least 2"); end
      if (BLOCK_THREADS > MAX_THREADS)    begin : g_e1 $error("block larger than thread budget"); end
      if (WARP_SIZE < 1)                  begin : g_e2 $error("WARP_SIZE must be positive"); end
      if (TW < $clog2(BLOCK_THREADS + 1)) begin : g_e3 $error("TW too narrow"); end
      if (UW < $clog2(MAX_THREADS + 1))   begin : g_e4 $error("UW too narrow"); end
   endgenerate

   logic [MAX_BLOCKS-1:0] slot_occ;
   logic [MAX_BLOCKS-1:0] busy_eff;
   logic                  rel_hit;
   logic [TW-1:0]         rel_thr;
   logic [SW-1:0]         free_idx;
   logic                  any_free;
   logic [WW-1:0]         warps_c;
   logic [BW-1:0]         blocks_eff;
   logic [UW-1:0]         threads_eff;
   logic [UW:0]           need_thr;
   logic                  size_bad;
   logic                  fits;
   logic                  take;
   logic                  hs;

   admit_slot_table #(.N(MAX_BLOCKS), .SW(SW), .TW(TW)) u_tab (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (take),
      .alloc_slot (free_idx),
      .alloc_thr  (req_threads),
      .rel_req    (done_valid),
      .rel_slot   (done_slot),
      .occ        (slot_occ),
      .rel_hit    (rel_hit),
      .rel_thr    (rel_thr)
   );

   always_comb begin
      busy_eff = slot_occ;
      for (int s = 0; s < MAX_BLOCKS; s++) begin
         if (rel_hit && int'(done_slot) == s) busy_eff[s] = 1'b0;
      end
   end

   admit_lowfree #(.N(MAX_BLOCKS), .IW(SW)) u_low (
      .busy     (busy_eff),
      .idx      (free_idx),
      .any_free (any_free)
   );

   admit_warps #(.TW(TW), .WW(WW), .WS(WARP_SIZE)) u_wrp (
      .threads (req_threads),
      .warps   (warps_c)
   );

   assign blocks_eff  = used_blocks - BW'(rel_hit);
   assign threads_eff = used_threads - UW'(rel_thr);
   assign need_thr    = {1'b0, threads_eff} + (UW+1)'(req_threads);
   assign size_bad    = (req_threads == '0) || (req_threads > TW'(BLOCK_THREADS));
   assign fits        = !size_bad && any_free
                        && (blocks_eff < BW'(MAX_BLOCKS))
                        && (need_thr <= (UW+1)'(MAX_THREADS));
   assign req_ready   = size_bad || fits;
   assign hs          = req_valid && req_ready;
   assign take        = req_valid && fits;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_blocks  <= '0;
         used_threads <= '0;
         resp_valid   <= 1'b0;
         resp_ok      <= 1'b0;
         resp_slot    <= '0;
         resp_warps   <= '0;
      end else begin
         used_blocks  <= blocks_eff + BW'(take);
         used_threads <= threads_eff + (take ? UW'(req_threads) : '0);
         resp_valid   <= hs;
         resp_ok      <= take;
         resp_slot    <= take ? free_idx : '0;
         resp_warps   <= take ? warps_c : '0;
      end
   end
endmodule

// File: rtl/admit_chk.sv
module admit_chk #(
   parameter int MAX_BLOCKS    = 8,
   parameter int MAX_THREADS   = 1536,
   parameter int BLOCK_THREADS = 1024,
   parameter int WARP_SIZE     = 32,
   parameter int TW = 11,
   parameter int SW = 3,
   parameter int WW = 6,
   parameter int BW = 4,
   parameter int UW = 11
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic [TW-1:0]         req_threads,
   input logic                  req_ready,
   input logic                  resp_valid,
   input logic                  resp_ok,
   input logic [SW-1:0]         resp_slot,
   input logic [WW-1:0]         resp_warps,
   input logic                  done_valid,
   input logic [SW-1:0]         done_slot,
   input logic [BW-1:0]         used_blocks,
   input logic [UW-1:0]         used_threads,
   input logic [MAX_BLOCKS-1:0] slot_occ
);
   a_r4_thread_cap: assert property (@(posedge clk) disable iff (!rst_n)
      int'(used_threads) <= MAX_THREADS);

   a_r3_block_cap: assert property (@(posedge clk) disable iff (!rst_n)
      int'(used_blocks) <= MAX_BLOCKS);

   a_r3_count_match: assert property (@(posedge clk) disable iff (!rst_n)
      int'(used_blocks) == $countones(slot_occ));

   a_r11_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> resp_valid);

   a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> (!resp_valid && !resp_ok));

   a_r2_bad_rejected: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_threads == '0 || int'(req_threads) > BLOCK_THREADS))
      |=> (resp_valid && !resp_ok));

   a_r5_warp_round: assert property (@(posedge clk) disable iff (!rst_n)
      resp_ok |-> ((int'(resp_warps) * WARP_SIZE >= int'($past(req_threads)))
                && (int'(resp_warps) * WARP_SIZE < int'($past(req_threads)) + WARP_SIZE)));

   a_r6_slot_marked: assert property (@(posedge clk) disable iff (!rst_n)
      resp_ok |-> slot_occ[resp_slot]);

   a_r8_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !slot_occ[done_slot] && !(req_valid && req_ready))
      |=> (used_threads == $past(used_threads)));
endmodule

bind sm_admit_ctrl admit_chk #(
   .MAX_BLOCKS(MAX_BLOCKS), .MAX_THREADS(MAX_THREADS),
   .BLOCK_THREADS(BLOCK_THREADS), .WARP_SIZE(WARP_SIZE),
   .TW(TW), .SW(SW), .WW(WW), .BW(BW), .UW(UW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
   .req_ready(req_ready), .resp_valid(resp_valid), .resp_ok(resp_ok),
   .resp_slot(resp_slot), .resp_warps(resp_warps), .done_valid(done_valid),
   .done_slot(done_slot), .used_blocks(used_blocks), .used_threads(used_threads),
   .slot_occ(slot_occ)
);

// File: tb/sim_sm_admit_ctrl.sv
`timescale 1ns/1ps
module sim_sm_admit_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [10:0] req_threads = '0;
   logic        req_ready;
   logic        resp_valid, resp_ok;
   logic [2:0]  resp_slot;
   logic [5:0]  resp_warps;
   logic        done_valid = 1'b0;
   logic [2:0]  done_slot = '0;
   logic [3:0]  used_blocks;
   logic [10:0] used_threads;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   // behavioural reference
   bit m_occ [8];
   int m_thr [8];
   int e_rv, e_ok, e_slot, e_warps, e_ub, e_ut;
   string last_tag = "R1";

   always #10 clk = ~clk;

   sm_admit_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
      .req_ready(req_ready), .resp_valid(resp_valid), .resp_ok(resp_ok),
      .resp_slot(resp_slot), .resp_warps(resp_warps), .done_valid(done_valid),
      .done_slot(done_slot), .used_blocks(used_blocks), .used_threads(used_threads)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_regs(input string tag);
      chk(tag, "resp_valid", int'(resp_valid), e_rv);
      chk(tag, "resp_ok", int'(resp_ok), e_ok);
      chk(tag, "resp_slot", int'(resp_slot), e_slot);
      chk(tag, "resp_warps", int'(resp_warps), e_warps);
      chk(tag, "used_blocks", int'(used_blocks), e_ub);
      chk(tag, "used_threads", int'(used_threads), e_ut);
   endtask

   // One cycle: check registered results of the previous cycle, drive, check ready, advance model
   task automatic step(input bit v, input int t, input bit dv, input int ds, input string tag);
      bit occ_e [8];
      int ub, ut, low;
      bit bad, ok, rdy, rel;
      @(negedge clk);
      #1;
      check_regs(last_tag);
      req_valid   = v;
      req_threads = 11'(t);
      done_valid  = dv;
      done_slot   = 3'(ds);
      #2;
      rel = dv && m_occ[ds];
      ub = e_ub; ut = e_ut;
      foreach (occ_e[i]) occ_e[i] = m_occ[i];
      if (rel) begin occ_e[ds] = 0; ub--; ut -= m_thr[ds]; end
      low = -1;
      for (int i = 7; i >= 0; i--) if (!occ_e[i]) low = i;
      bad = (t < 1) || (t > 1024);
      ok  = !bad && low >= 0 && ub < 8 && (ut + t) <= 1536;
      rdy = bad || ok;
      chk(tag, "req_ready", int'(req_ready), int'(rdy));
      if (rel) m_occ[ds] = 0;
      e_rv = int'(v && rdy);
      e_ok = int'(v && ok);
      e_slot = 0; e_warps = 0;
      if (v && ok) begin
         m_occ[low] = 1; m_thr[low] = t; ub++; ut += t;
         e_slot = low; e_warps = (t + 31) / 32;
      end
      e_ub = ub; e_ut = ut;
      last_tag = tag;
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, 0, tag);
   endtask

   task automatic release_all(input string tag);
      for (int s = 0; s < 8; s++) step(0, 0, 1, s, tag);
      idle(tag);
   endtask

   initial begin
      e_rv = 0; e_ok = 0; e_slot = 0; e_warps = 0; e_ub = 0; e_ut = 0;
      foreach (m_occ[i]) begin m_occ[i] = 0; m_thr[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state and readiness
      idle("R1");
      step(0, 100, 0, 0, "R1");
      idle("R1");
      // R2 malformed sizes are consumed and refused
      step(1, 0, 0, 0, "R2");
      step(1, 1025, 0, 0, "R2");
      step(1, 2047, 0, 0, "R2");
      idle("R2");
      // R3 slot limit binds with 64-thread blocks; R6 lowest slot order
      for (int k = 0; k < 8; k++) step(1, 64, 0, 0, "R6");
      idle("R3");
      chk("R3", "used_threads at slot limit", int'(used_threads), 512);
      // R10 stall holds
      step(1, 64, 0, 0, "R10");
      step(1, 64, 0, 0, "R10");
      // R9 release and admit in same cycle, slot 3 reused
      step(1, 64, 1, 3, "R9");
      idle("R9");
      chk("R9", "slot reused", 1, int'(m_occ[3]));
      // R7 exact release
      step(0, 0, 1, 5, "R7");
      idle("R7");
      // R8 stray completion on a freed slot
      step(0, 0, 1, 5, "R8");
      step(0, 0, 1, 5, "R8");
      idle("R8");
      release_all("R7");
      // R4 thread limit binds with 256-thread blocks
      for (int k = 0; k < 6; k++) step(1, 256, 0, 0, "R5");
      step(1, 256, 0, 0, "R4");
      step(1, 256, 0, 0, "R4");
      step(0, 0, 1, 2, "R7");
      step(1, 256, 0, 0, "R10");
      idle("R6");
      release_all("R7");
      // R5 warp rounding
      step(1, 1, 0, 0, "R5");
      step(1, 33, 0, 0, "R5");
      step(1, 32, 0, 0, "R5");
      idle("R5");
      release_all("R5");
      step(1, 1024, 0, 0, "R5");
      step(1, 600, 0, 0, "R4");
      step(1, 512, 0, 0, "R4");
      step(1, 1, 0, 0, "R4");
      step(1, 1, 1, 0, "R9");
      idle("R11");
      release_all("R11");
      idle("R11");
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL R11 watchdog: actual %0d expected %0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule